// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes an SDRAM device from power-up to normal operation with no processor involvement. When started after reset it writes the two bank-group configuration words and a timing word whose refresh-control field is forced off. It then issues a single NOP and waits out the power-up settle time. Next it plays a fixed command list: one precharge-all, a run of auto-refresh commands and one load-mode command, spaced by a minimum gap. Finally it writes the full timing word, which switches periodic refresh back on, and raises a sticky done flag.

The mode payload carried with each list command is derived from the CAS latency, taken from the timing word, and from the bus width, taken from the group-0 configuration word. A nonzero override word replaces the derived payload. Both waits are down-counters whose load values come from a clock-period parameter and are rounded up to whole cycles. The configuration inputs are expected to stay stable while the sequence runs.

Top module: `sdram_init_seq`

## Requirements
- R1: One cycle after `start` is sampled high in idle, the block makes three register writes on consecutive cycles: select 0 with `grp0_cfg`, select 1 with `grp1_cfg`, then select 2 with `timing_cfg` with its 2-bit refresh field at bit `REF_LSB` cleared. No write and no command strobe are ever active in the same cycle.
- R2: The cycle after the third write, a NOP is strobed (code 0). The first list command follows exactly ceil(SETTLE_NS*1000/CLK_PS) cycles after the NOP.
- R3: The list commands are strobed in this order: one precharge (code 1), `N_REF` auto-refresh (code 2), one mode-register-set (code 3).
- R4: Consecutive list commands are exactly ceil(GAP_NS*1000/CLK_PS) cycles apart, and the strobe lasts one cycle.
- R5: With a zero override, the payload is 0x40 when `timing_cfg[2:0]` is 2 and 0x60 otherwise. If `grp0_cfg[9]` is 1 (16-bit bus) these become 0x20 and 0x30.
- R6: With a nonzero `cmd_override`, the override is the payload, whatever the CAS latency and width bits hold.
- R7: For every list command `cmd_word` equals (payload << 2) OR code, truncated to 32 bits. For the NOP it equals 0.
- R8: The cycle after the mode-register-set, the full `timing_cfg` is written at select 2. `done` rises the following cycle and stays high until reset.
- R9: Reset clears `done` and all strobes, and the block stays silent until `start`. The sequence runs once: `start` while running or done produces no further writes or commands. A reset in mid-sequence stops all activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins the sequence when sampled in idle |
| grp0_cfg | input | 32 | Bank group 0 configuration word; bit 9 selects 16-bit bus |
| grp1_cfg | input | 32 | Bank group 1 configuration word |
| timing_cfg | input | 32 | Timing word; bits 2:0 CAS latency, 2-bit refresh field at REF_LSB |
| cmd_override | input | 32 | Nonzero value replaces the derived mode payload |
| reg_wr_en | output | 1 | Register write strobe |
| reg_wr_sel | output | 2 | Write target: 0 group 0, 1 group 1, 2 timing |
| reg_wr_data | output | 32 | Write data |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_code | output | 3 | Command code: 0 NOP, 1 precharge, 2 auto-refresh, 3 mode set |
| cmd_word | output | 32 | Command word with payload shifted up by two |
| done | output | 1 | Sticky completion flag |

## Verification
The bench sweeps all eight CAS-latency codes against both bus widths with the override at zero. This separates the latency-2 case from every other code treated as latency 3, and shows the halving on the narrow bus. Runs with nonzero override words, one with high bits that shifting drops, show that the override masks the derived value. Odd nanosecond settings make both wait counts land on rounded-up cycle totals, so an off-by-one in either counter moves a strobe by a cycle. A second start after completion and a reset mid-run confirm that the sequence runs once and that reset stops it.

// File: rtl/sdram_init_seq.sv
module sdram_init_seq #(
  parameter int CLK_PS    = 5000,
  parameter int SETTLE_NS = 200000,
  parameter int GAP_NS    = 80,
  parameter int N_REF     = 8,
  parameter int REF_LSB   = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [31:0] grp0_cfg,
  input  logic [31:0] grp1_cfg,
  input  logic [31:0] timing_cfg,
  input  logic [31:0] cmd_override,
  output logic        reg_wr_en,
  output logic [1:0]  reg_wr_sel,
  output logic [31:0] reg_wr_data,
  output logic        cmd_valid,
  output logic [2:0]  cmd_code,
  output logic [31:0] cmd_word,
  output logic        done
);
  localparam int SETTLE_CYC = (SETTLE_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int GAP_CYC    = (GAP_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int MAXC       = (SETTLE_CYC > GAP_CYC) ? SETTLE_CYC : GAP_CYC;
  localparam int CW         = $clog2(MAXC + 1);
  localparam int IW         = $clog2(N_REF + 2);
  localparam logic [CW-1:0] SETTLE_LD = CW'(SETTLE_CYC - 2);
  localparam logic [CW-1:0] GAP_LD    = CW'(GAP_CYC - 2);
  localparam logic [IW-1:0] LAST_I    = IW'(N_REF + 1);
  localparam logic [31:0]   REF_MASK  = 32'h3 << REF_LSB;

  localparam logic [2:0] C_NOP = 3'd0, C_PRE = 3'd1, C_REF = 3'd2, C_MRS = 3'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_G0, S_G1, S_T0, S_NOP, S_WAIT, S_CMD, S_GAP, S_T1, S_DONE
  } st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;

  wire        cl2     = timing_cfg[2:0] == 3'd2;
  wire [31:0] derived = grp0_cfg[9] ? (cl2 ? 32'h20 : 32'h30) : (cl2 ? 32'h40 : 32'h60);
  wire [31:0] payload = (|cmd_override) ? cmd_override : derived;
  wire [2:0]  lcode   = (idx == '0) ? C_PRE : (idx == LAST_I) ? C_MRS : C_REF;

  assign reg_wr_en   = state inside {S_G0, S_G1, S_T0, S_T1};
  assign reg_wr_sel  = (state == S_G0) ? 2'd0 : (state == S_G1) ? 2'd1 : 2'd2;
  assign reg_wr_data = (state == S_G0) ? grp0_cfg :
                       (state == S_G1) ? grp1_cfg :
                       (state == S_T0) ? (timing_cfg & ~REF_MASK) : timing_cfg;
  assign cmd_valid   = (state == S_NOP) || (state == S_CMD);
  assign cmd_code    = (state == S_NOP) ? C_NOP : lcode;
  assign cmd_word    = (state == S_NOP) ? 32'd0 : ((payload << 2) | {29'd0, lcode});
  assign done        = state == S_DONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      cnt   <= '0;
      idx   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) state <= S_G0;
        S_G0:   state <= S_G1;
        S_G1:   state <= S_T0;
        S_T0:   state <= S_NOP;
        S_NOP: begin
          cnt   <= SETTLE_LD;
          idx   <= '0;
          state <= S_WAIT;
        end
        S_WAIT:
          if (cnt == '0) state <= S_CMD;
          else cnt <= cnt - 1'b1;
        S_CMD:
          if (idx == LAST_I) state <= S_T1;
          else begin
            cnt   <= GAP_LD;
            idx   <= idx + 1'b1;
            state <= S_GAP;
          end
        S_GAP:
          if (cnt == '0) state <= S_CMD;
          else cnt <= cnt - 1'b1;
        S_T1:   state <= S_DONE;
        S_DONE: state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  p_excl_r1: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr_en && cmd_valid));

  p_gap_r4: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);

  p_mrs_timing_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_code == C_MRS) |=> (reg_wr_en && reg_wr_sel == 2'd2 && reg_wr_data == timing_cfg));

  p_done_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  p_done_rise_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(reg_wr_en && reg_wr_sel == 2'd2));

  p_quiet_done_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> (!reg_wr_en && !cmd_valid));
endmodule

// File: tb/tb_sdram_init_seq.sv
`timescale 1ns/1ps
module tb_sdram_init_seq;
  localparam int CLK_PS = 5000, SETTLE_NS = 2001, GAP_NS = 83, NREF = 8, RLSB = 4;
  localparam int SC = 401;
  localparam int GC = 17;

  logic clk = 0, rst = 1, start = 0;
  logic [31:0] grp0_cfg = 0, grp1_cfg = 0, timing_cfg = 0, cmd_override = 0;
  logic reg_wr_en, cmd_valid, done;
  logic [1:0] reg_wr_sel;
  logic [31:0] reg_wr_data, cmd_word;
  logic [2:0] cmd_code;

  sdram_init_seq #(.CLK_PS(CLK_PS), .SETTLE_NS(SETTLE_NS), .GAP_NS(GAP_NS),
                   .N_REF(NREF), .REF_LSB(RLSB)) dut (.*);

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_cmp = 0, n_bad = 0;
  int nw, nc, done_cyc;
  int wsel[16], wcyc[16], ccode[16], ccyc[16];
  logic [31:0] wdat[16], cword[16];

  always @(negedge clk) begin
    if (reg_wr_en && nw < 16) begin
      wsel[nw] = reg_wr_sel; wdat[nw] = reg_wr_data; wcyc[nw] = cyc; nw++;
    end
    if (cmd_valid && nc < 16) begin
      ccode[nc] = cmd_code; cword[nc] = cmd_word; ccyc[nc] = cyc; nc++;
    end
    if (done && done_cyc < 0) done_cyc = cyc;
  end

  task automatic chk(string req, string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_log();
    nw = 0; nc = 0; done_cyc = -1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    chk("R9", "reset wr_en", reg_wr_en, 0);
    chk("R9", "reset cmd_valid", cmd_valid, 0);
    chk("R9", "reset done", done, 0);
  endtask

  task automatic run(logic [31:0] g0, logic [31:0] g1, logic [31:0] tm, logic [31:0] ov);
    logic [31:0] p, w;
    int s0;
    grp0_cfg = g0; grp1_cfg = g1; timing_cfg = tm; cmd_override = ov;
    do_reset();
    clear_log();
    repeat (4) @(negedge clk);
    chk("R9", "idle writes", nw, 0);
    chk("R9", "idle cmds", nc, 0);
    start = 1; s0 = cyc;
    @(negedge clk); start = 0;
    for (int k = 0; k < 3000 && done_cyc < 0; k++) @(negedge clk);
    chk("R8", "done reached", done_cyc >= 0, 1);
    start = 1; @(negedge clk); start = 0;
    repeat (40) @(negedge clk);
    chk("R9", "write count once", nw, 4);
    chk("R9", "cmd count once", nc, NREF + 3);
    chk("R8", "done held", done, 1);
    if (nw != 4 || nc != NREF + 3) return;

    p = (tm[2:0] == 3'd2) ? 32'h40 : 32'h60;
    if (g0[9]) p = p >> 1;
    if (ov != 0) p = ov;

    chk("R1", "w0 sel", wsel[0], 0); chk("R1", "w0 data", wdat[0], g0); chk("R1", "w0 cyc", wcyc[0], s0 + 1);
    chk("R1", "w1 sel", wsel[1], 1); chk("R1", "w1 data", wdat[1], g1); chk("R1", "w1 cyc", wcyc[1], s0 + 2);
    chk("R1", "w2 sel", wsel[2], 2); chk("R1", "w2 data", wdat[2], tm & ~(32'h3 << RLSB));
    chk("R1", "w2 cyc", wcyc[2], s0 + 3);
    chk("R2", "nop code", ccode[0], 0); chk("R7", "nop word", cword[0], 0);
    chk("R2", "nop cyc", ccyc[0], s0 + 4);
    chk("R2", "settle gap", ccyc[1] - ccyc[0], SC);
    for (int i = 1; i <= NREF + 2; i++) begin
      int code = (i == 1) ? 1 : (i == NREF + 2) ? 3 : 2;
      chk("R3", $sformatf("cmd%0d code", i), ccode[i], code);
      w = (p << 2) | code;
      chk(ov != 0 ? "R6" : "R5", $sformatf("cmd%0d word", i), cword[i], w);
      if (i >= 2) chk("R4", $sformatf("gap%0d", i), ccyc[i] - ccyc[i-1], GC);
    end
    chk("R8", "w3 sel", wsel[3], 2); chk("R8", "w3 data", wdat[3], tm);
    chk("R8", "w3 cyc", wcyc[3], ccyc[NREF + 2] + 1);
    chk("R8", "done cyc", done_cyc, wcyc[3] + 1);
  endtask

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int cl = 0; cl < 8; cl++)
      for (int wd = 0; wd < 2; wd++)
        run(32'h1234_0005 | (wd << 9), 32'h0BAD_0200 ^ cl,
            32'h00C0_0100 | cl | ((cl % 4) << RLSB) | (wd << 12), 32'h0);
    run(32'h0000_0200, 32'h1, 32'h0000_0032, 32'h0000_0015);
    run(32'h0, 32'h2, 32'h0000_0007, 32'hFFFF_FFFF);
    run(32'h0000_0200, 32'h3, 32'h0000_0002, 32'h0000_0001);

    // R9: reset in mid-sequence stops all activity
    grp0_cfg = 32'h5; timing_cfg = 32'h32; cmd_override = 0;
    do_reset();
    clear_log();
    start = 1; @(negedge clk); start = 0;
    repeat (450) @(negedge clk);
    rst = 1; @(negedge clk); rst = 0;
    clear_log();
    chk("R9", "midreset done", done, 0);
    repeat (60) @(negedge clk);
    chk("R9", "midreset writes", nw, 0);
    chk("R9", "midreset cmds", nc, 0);
    chk("R9", "midreset done later", done, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule